// File: doc/BRIEF.md
# DDR ADC Capture Receiver

This block sits at the pin edge of a dual-channel converter link. It is clocked by the converter's forwarded output clock. Each channel brings in a bus of sample pins, and two overflow pins are shared by both channels. In double-data-rate mode each channel uses only the odd pin positions. Each of those lines carries two bits of the sample: an even bit in the clock-low half of the period and the next odd bit in the clock-high half. One of the overflow pins is also time-shared: it carries the second channel's flag in the low half and the first channel's flag in the high half.

The receiver takes the low half on the falling edge and the high half on the rising edge. The forwarded clock is assumed to sit a quarter period away from the data transitions. The receiver then interleaves the two halves back into one full-width word per channel and routes the shared overflow line to the right channel. A word flag and a one-cycle valid strobe are registered at the rising edge that completes the pair. A full-rate mode can be selected instead. In that mode every pin carries its own bit, and the whole bus and both overflow pins are sampled on the rising edge.

Top module: `adc_ddr_capture_rx`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_fwd`, both words, both overflow flags and `word_valid` go to zero.
- R2: In DDR mode (`full_rate_sel`=0), DDR line k of a channel is pin position 2k+1 of that channel's pin bus. The value on that pin at a falling edge becomes word bit 2k. The value at the next rising edge becomes word bit 2k+1, with bit 13 as the MSB. Even pin positions are ignored.
- R3: In DDR mode the shared overflow line is `ovf_pins[0]`. Its value at the falling edge becomes `ch2_ovf`, and its value at the next rising edge becomes `ch1_ovf`. `ovf_pins[1]` is ignored.
- R4: A word is presented, with `word_valid` high for exactly one cycle, right after the rising edge that completes a low/high pair. Rising edges that complete no pair leave `word_valid` low.
- R5: After reset, a rising edge with no falling-edge capture since reset produces no word.
- R6: At the first rising edge in DDR mode that follows a rising edge in full-rate mode, the half-pair is discarded and no word is produced.
- R7: In full-rate mode (`full_rate_sel`=1), each rising edge registers both full pin buses as the words, `ovf_pins[0]` as `ch1_ovf` and `ovf_pins[1]` as `ch2_ovf`, with `word_valid` high.
- R8: Words and overflow flags hold their values in every cycle where `word_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fwd | input | 1 | Forwarded output clock from the converter |
| rst | input | 1 | Synchronous active-high reset |
| full_rate_sel | input | 1 | 1 selects full-rate capture, 0 selects DDR capture |
| ch1_pins | input | WORD_W | Channel 1 sample pins |
| ch2_pins | input | WORD_W | Channel 2 sample pins |
| ovf_pins | input | 2 | Overflow pins; bit 0 is shared in DDR mode |
| ch1_word | output | WORD_W | Channel 1 reassembled sample |
| ch2_word | output | WORD_W | Channel 2 reassembled sample |
| ch1_ovf | output | 1 | Channel 1 overflow flag |
| ch2_ovf | output | 1 | Channel 2 overflow flag |
| word_valid | output | 1 | One-cycle strobe per new word |

## Verification
The internal state is small: the falling-edge half registers, a capture toggle, its rising-edge acknowledge and the registered mode. Each fault in it shows up at the ports within one clock period. A toggle that falls out of step with its acknowledge makes a word appear one cycle early, one cycle late, or not at all, which breaks the cycle stamp on the expected word. A swapped half or a swapped overflow phase corrupts every word in a stream of distinct patterns. Forgetting the previous mode shows up as a spurious word on the first DDR edge after full-rate operation.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef enum logic {
    RX_MODE_DDR  = 1'b0,
    RX_MODE_FULL = 1'b1
  } rx_mode_e;

  localparam int unsigned RX_NCH = 2;
endpackage

// File: rtl/adc_rx_low_capture.sv
// Falling-edge capture of the clock-low half of every DDR line and of the
// shared overflow line; a toggle marks each new capture for the rising side.
module adc_rx_low_capture
  import adc_rx_pkg::*;
#(
  parameter int unsigned LINES = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [RX_NCH-1:0][LINES-1:0]  lines_in,
  input  logic                          ovf_line,
  output logic [RX_NCH-1:0][LINES-1:0]  lo_q,
  output logic                          ovf_lo_q,
  output logic                          lo_tog
);

  always_ff @(negedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      ovf_lo_q <= 1'b0;
      lo_tog   <= 1'b0;
    end else begin
      lo_q     <= lines_in;
      ovf_lo_q <= ovf_line;
      lo_tog   <= ~lo_tog;
    end
  end

endmodule

// File: rtl/adc_rx_pair_ctrl.sv
// Rising-edge pairing: a word completes when a low half was captured since the
// previous rising edge and DDR mode was already active at that edge.
module adc_rx_pair_ctrl
  import adc_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rx_mode_e mode,
  input  logic     lo_tog,
  output logic     pair_fire
);

  logic     ack_q;
  rx_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      mode_q <= RX_MODE_DDR;
    end else begin
      ack_q  <= lo_tog;
      mode_q <= mode;
    end
  end

  assign pair_fire = (mode == RX_MODE_DDR) && (mode_q == RX_MODE_DDR) &&
                     (lo_tog != ack_q);

endmodule

// File: rtl/adc_rx_interleave.sv
// Rebuilds a word: low-half line k lands on bit 2k, high-half line k on 2k+1.
module adc_rx_interleave #(
  parameter int unsigned LINES = 7
) (
  input  logic [LINES-1:0]   lo,
  input  logic [LINES-1:0]   hi,
  output logic [2*LINES-1:0] word
);

  for (genvar k = 0; k < LINES; k++) begin : g_bit
    assign word[2*k]   = lo[k];
    assign word[2*k+1] = hi[k];
  end

endmodule

// File: rtl/adc_ddr_capture_rx.sv
module adc_ddr_capture_rx
  import adc_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk_fwd,
  input  logic              rst,
  input  logic              full_rate_sel,
  input  logic [WORD_W-1:0] ch1_pins,
  input  logic [WORD_W-1:0] ch2_pins,
  input  logic [1:0]        ovf_pins,
  output logic [WORD_W-1:0] ch1_word,
  output logic [WORD_W-1:0] ch2_word,
  output logic              ch1_ovf,
  output logic              ch2_ovf,
  output logic              word_valid
);

  localparam int unsigned LINES = WORD_W / 2;

  rx_mode_e                          mode;
  logic [RX_NCH-1:0][WORD_W-1:0]     pins_all;
  logic [RX_NCH-1:0][LINES-1:0]      ddr_now;
  logic [RX_NCH-1:0][LINES-1:0]      lo_q;
  logic [RX_NCH-1:0][WORD_W-1:0]     ddr_word;
  logic [RX_NCH-1:0][WORD_W-1:0]     word_q;
  logic [RX_NCH-1:0]                 ovf_q;
  logic                              ovf_lo_q;
  logic                              lo_tog;
  logic                              pair_fire;
  logic                              valid_q;

  assign mode        = full_rate_sel ? RX_MODE_FULL : RX_MODE_DDR;
  assign pins_all[0] = ch1_pins;
  assign pins_all[1] = ch2_pins;

  // DDR lines occupy the odd pin positions of each channel bus
  for (genvar c = 0; c < RX_NCH; c++) begin : g_ch
    for (genvar k = 0; k < LINES; k++) begin : g_line
      assign ddr_now[c][k] = pins_all[c][2*k+1];
    end

    adc_rx_interleave #(.LINES(LINES)) i_interleave (
      .lo   (lo_q[c]),
      .hi   (ddr_now[c]),
      .word (ddr_word[c])
    );
  end

  adc_rx_low_capture #(.LINES(LINES)) i_low_capture (
    .clk      (clk_fwd),
    .rst      (rst),
    .lines_in (ddr_now),
    .ovf_line (ovf_pins[0]),
    .lo_q     (lo_q),
    .ovf_lo_q (ovf_lo_q),
    .lo_tog   (lo_tog)
  );

  adc_rx_pair_ctrl i_pair_ctrl (
    .clk       (clk_fwd),
    .rst       (rst),
    .mode      (mode),
    .lo_tog    (lo_tog),
    .pair_fire (pair_fire)
  );

  // Output registers: full-rate passthrough or completed DDR pair
  always_ff @(posedge clk_fwd) begin
    if (rst) begin
      word_q  <= '0;
      ovf_q   <= '0;
      valid_q <= 1'b0;
    end else if (mode == RX_MODE_FULL) begin
      word_q  <= pins_all;
      ovf_q   <= ovf_pins;
      valid_q <= 1'b1;
    end else if (pair_fire) begin
      word_q  <= ddr_word;
      ovf_q   <= {ovf_lo_q, ovf_pins[0]};
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign ch1_word   = word_q[0];
  assign ch2_word   = word_q[1];
  assign ch1_ovf    = ovf_q[0];
  assign ch2_ovf    = ovf_q[1];
  assign word_valid = valid_q;

  AST_FULL_WORDS: assert property (@(posedge clk_fwd) disable iff (rst)
    full_rate_sel |=> (ch1_word == $past(ch1_pins)) && (ch2_word == $past(ch2_pins)) && word_valid); // R7

  AST_FULL_FLAGS: assert property (@(posedge clk_fwd) disable iff (rst)
    full_rate_sel |=> (ch1_ovf == $past(ovf_pins[0])) && (ch2_ovf == $past(ovf_pins[1]))); // R7

  AST_MODE_ENTRY_DISCARD: assert property (@(posedge clk_fwd) disable iff (rst)
    (!full_rate_sel && $past(full_rate_sel)) |=> !word_valid); // R6

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_fwd) disable iff (rst)
    (!word_valid && !$past(rst)) |-> ($stable(ch1_word) && $stable(ch2_word) &&
                                      $stable(ch1_ovf) && $stable(ch2_ovf))); // R8

  AST_DDR_HIGH_FLAG: assert property (@(posedge clk_fwd) disable iff (rst)
    (pair_fire && !full_rate_sel) |=> (word_valid && ch1_ovf == $past(ovf_pins[0]))); // R3

endmodule

// File: tb/test_adc_ddr_capture_rx.sv
`timescale 1ns/1ps
module test_adc_ddr_capture_rx;
  localparam int unsigned W = 14;

  logic         clk_fwd = 1'b0;
  logic         rst = 1'b1;
  logic         full_rate_sel = 1'b0;
  logic [W-1:0] ch1_pins = '0;
  logic [W-1:0] ch2_pins = '0;
  logic [1:0]   ovf_pins = '0;
  logic [W-1:0] ch1_word, ch2_word;
  logic         ch1_ovf, ch2_ovf, word_valid;

  adc_ddr_capture_rx #(.WORD_W(W)) i_adc_ddr_capture_rx (
    .clk_fwd(clk_fwd), .rst(rst), .full_rate_sel(full_rate_sel),
    .ch1_pins(ch1_pins), .ch2_pins(ch2_pins), .ovf_pins(ovf_pins),
    .ch1_word(ch1_word), .ch2_word(ch2_word), .ch1_ovf(ch1_ovf),
    .ch2_ovf(ch2_ovf), .word_valid(word_valid)
  );

  always #4 clk_fwd = ~clk_fwd;   // 125 MHz

  typedef struct {
    logic [W-1:0] w1;
    logic [W-1:0] w2;
    logic         o1;
    logic         o2;
    bit           full;
    int           cyc;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always @(posedge clk_fwd) cyc = cyc + 1;

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at rising edge + 2 ns; returns at the next rising edge + 2 ns
  task automatic ddr_word(input logic [W-1:0] w1, input logic [W-1:0] w2,
                          input logic o1, input logic o2);
    exp_t e;
    ch1_pins = W'($urandom);
    ch2_pins = W'($urandom);
    ovf_pins = 2'($urandom);
    for (int k = 0; k < W/2; k++) begin
      ch1_pins[2*k+1] = w1[2*k];
      ch2_pins[2*k+1] = w2[2*k];
    end
    ovf_pins[0] = o2;
    @(negedge clk_fwd); #2;
    ch1_pins = W'($urandom);
    ch2_pins = W'($urandom);
    ovf_pins = 2'($urandom);
    for (int k = 0; k < W/2; k++) begin
      ch1_pins[2*k+1] = w1[2*k+1];
      ch2_pins[2*k+1] = w2[2*k+1];
    end
    ovf_pins[0] = o1;
    e.w1 = w1; e.w2 = w2; e.o1 = o1; e.o2 = o2; e.full = 1'b0; e.cyc = cyc + 1;
    exp_q.push_back(e);
    @(posedge clk_fwd); #2;
  endtask

  task automatic full_word(input logic [W-1:0] w1, input logic [W-1:0] w2,
                           input logic o1, input logic o2);
    exp_t e;
    @(negedge clk_fwd); #2;
    ch1_pins = w1; ch2_pins = w2; ovf_pins = {o2, o1};
    e.w1 = w1; e.w2 = w2; e.o1 = o1; e.o2 = o2; e.full = 1'b1; e.cyc = cyc + 1;
    exp_q.push_back(e);
    @(posedge clk_fwd); #2;
  endtask

  // Scoreboard monitor
  initial begin : monitor
    logic [W-1:0] l1, l2;
    logic         lo1, lo2;
    exp_t         e;
    l1 = '0; l2 = '0; lo1 = 1'b0; lo2 = 1'b0;
    forever begin
      @(posedge clk_fwd); #1;
      if (rst) begin
        l1 = '0; l2 = '0; lo1 = 1'b0; lo2 = 1'b0;
      end else if (word_valid) begin
        if (exp_q.size() == 0) begin
          chk_eq("R4", "unexpected word_valid", 32'(word_valid), 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk_eq("R4", "word cycle", 32'(cyc), 32'(e.cyc));
          chk_eq(e.full ? "R7" : "R2", "ch1_word", 32'(ch1_word), 32'(e.w1));
          chk_eq(e.full ? "R7" : "R2", "ch2_word", 32'(ch2_word), 32'(e.w2));
          chk_eq(e.full ? "R7" : "R3", "ch1_ovf", 32'(ch1_ovf), 32'(e.o1));
          chk_eq(e.full ? "R7" : "R3", "ch2_ovf", 32'(ch2_ovf), 32'(e.o2));
        end
        l1 = ch1_word; l2 = ch2_word; lo1 = ch1_ovf; lo2 = ch2_ovf;
      end else begin
        // R8: outputs hold while no word is presented
        chk_eq("R8", "held words", 32'({ch1_word, ch2_word}), 32'({l1, l2}));
        chk_eq("R8", "held flags", 32'({ch1_ovf, ch2_ovf}), 32'({lo1, lo2}));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    repeat (4) @(posedge clk_fwd);
    #1;
    // R1: reset state
    chk_eq("R1", "word_valid", 32'(word_valid), 32'd0);
    chk_eq("R1", "ch1_word", 32'(ch1_word), 32'd0);
    chk_eq("R1", "ch2_word", 32'(ch2_word), 32'd0);
    chk_eq("R1", "flags", 32'({ch1_ovf, ch2_ovf}), 32'd0);

    // R5: release between edges so a high half arrives with no low half before it
    @(negedge clk_fwd); #2;
    rst = 1'b0;
    ch1_pins = '1; ch2_pins = '1; ovf_pins = 2'b11;
    @(posedge clk_fwd); #1;
    chk_eq("R5", "orphan high half", 32'(word_valid), 32'd0);
    #1;

    // R2 R3 R4: continuous DDR stream with distinct patterns
    ddr_word(14'h0000, 14'h3FFF, 1'b0, 1'b1);
    ddr_word(14'h3FFF, 14'h0000, 1'b1, 1'b0);
    ddr_word(14'h2AAA, 14'h1555, 1'b1, 1'b1);
    ddr_word(14'h1555, 14'h2AAA, 1'b0, 1'b0);
    ddr_word(14'h2000, 14'h0001, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++)
      ddr_word(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));

    // R7: full-rate passthrough
    full_rate_sel = 1'b1;
    full_word(14'h3FFF, 14'h0000, 1'b1, 1'b0);
    full_word(14'h1234, 14'h2BCD, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++)
      full_word(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));

    // R6: first rising edge back in DDR mode yields no word
    full_rate_sel = 1'b0;
    ch1_pins = W'($urandom); ch2_pins = W'($urandom); ovf_pins = 2'($urandom);
    @(posedge clk_fwd); #1;
    chk_eq("R6", "entry discard", 32'(word_valid), 32'd0);
    #1;
    for (int i = 0; i < 5; i++)
      ddr_word(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));

    // R1 again, and R4: every expected word was produced
    rst = 1'b1;
    @(posedge clk_fwd); #1;
    chk_eq("R1", "word_valid in reset", 32'(word_valid), 32'd0);
    chk_eq("R1", "words in reset", 32'({ch1_word, ch2_word}), 32'd0);
    chk_eq("R4", "pending words", 32'(exp_q.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule